// File: doc/BRIEF.md
# Burst Serial Port with Byte Queue

This block is an 8-bit clocked serial port that moves a burst of one to eight bytes with a single start command. Software fills an eight-entry byte queue through a small register interface, sets the burst length and the clock role, and writes the start bit. The port then shifts the bytes out most significant bit first. The byte received in each frame overwrites the entry that was just sent, so when the burst ends the queue holds the received bytes in arrival order. Software reads them back from the same data address.

As clock master the port drives SCK with a period of 2*SCK_HALF system clocks. As slave it follows an external SCK through a synchronizer. In both roles a chip-select input gates the port. While the port is deselected the data output enable is low, and so is the clock output enable in master role. A new selection counts only after chip select has been inactive for at least CS_GAP system clocks. If chip select drops while a burst is in progress, the burst is abandoned and an error flag is set.

Top module: `ssp_burst`

## Requirements
- R1: After reset, busy is low, the done and error flags are zero, STAT and CTRL read 0x00, sck_o is high, and both sck_oe and so_oe are low.
- R2: A write to DATA (address 1) stores the byte at the queue pointer and advances the pointer. A read of DATA returns the byte at the pointer and advances it. Any accepted write to CTRL (address 0) returns the pointer to entry 0.
- R3: In master role the start write's clock edge begins the burst. sck_o falls on the next clock and then repeats a pattern of SCK_HALF clocks low followed by SCK_HALF clocks high. sck_o rests high when no burst is running.
- R4: Each byte goes out most significant bit first. so_o takes its new bit when SCK falls, and si_i is sampled when SCK rises.
- R5: CTRL bits 3:1 hold the burst length minus one. A burst moves that many plus one bytes, starting at entry 0. The received byte k replaces entry k. busy_o is high from the start edge until the clock edge that samples the last bit.
- R6: done_o pulses high for exactly one clock at the end of a complete burst. The sticky done flag (STAT bit 1) is then set. Writing 1 to STAT bit 1 clears it.
- R7: so_oe is high only while the chip-select gate is open. sck_oe is high only in master role with the gate open. The gate opens when cs_n_i goes low only if it had been high for at least CS_GAP consecutive clocks.
- R8: In slave role (CTRL bit 0 = 0) the port shifts on the synchronized edges of sck_i and on the synchronized si_i.
- R9: If the gate closes during a burst, busy clears without a done pulse and the error flag (STAT bit 2, write 1 to clear) is set. The next burst starts again from bit 0.
- R10: While busy, writes to CTRL and DATA are ignored. The configuration and the queue pointer are left unchanged.
- R11: STAT bit 0 reads the busy state. CTRL reads back the role in bit 0 and the length field in bits 3:1. Bit 7 (start) of CTRL is write-only and reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; rdata is valid the next clock |
| addr | input | 2 | Register select: 0 CTRL, 1 DATA, 2 STAT |
| wdata | input | DATA_W | Register write data |
| rdata | output | DATA_W | Registered read data |
| sck_i | input | 1 | Serial clock from an external master (slave role) |
| sck_o | output | 1 | Serial clock driven in master role |
| sck_oe | output | 1 | Output enable for the serial clock pad |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for the serial data pad |
| cs_n_i | input | 1 | Active-low chip select |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-clock pulse at burst completion |

## Verification
The bench builds the port with SCK_HALF = 3, which gives an odd half period. An off-by-one in the clock divider then shifts every later edge of a full eight-byte burst, and the per-clock comparison catches it. DEPTH = 8 and CS_GAP = 2 keep the full queue and the shortest legal deselect time within reach. With these values a one-clock chip-select glitch can be shown to keep the port closed, while a three-clock deselect reopens it. In slave role the bench drives sck_i with a half period of six clocks, which gives the two-stage synchronizer room to settle before so_o is sampled.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_DATA = 2'd1,
    REG_STAT = 2'd2
  } ssp_reg_e;

  localparam int STAT_BUSY = 0;
  localparam int STAT_DONE = 1;
  localparam int STAT_ERR  = 2;
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= INIT;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/ssp_csgate.sv
module ssp_csgate #(
  parameter int GAP = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_s,
  output logic en
);
  localparam int GW = $clog2(GAP + 1);
  localparam logic [GW-1:0] GAP_V = GW'(GAP);

  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap <= GAP_V;
      en  <= 1'b0;
    end else if (cs_n_s) begin
      en <= 1'b0;
      if (gap != GAP_V) gap <= gap + GW'(1);
    end else begin
      gap <= '0;
      if (gap == GAP_V) en <= 1'b1;
    end
  end

  // R7
  gap_met_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(en) |-> $past(gap) == GAP_V);
endmodule

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int W = 8,
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cpu_we,
  input  logic                     cpu_re,
  input  logic                     rewind,
  input  logic [W-1:0]             cpu_wdata,
  output logic [W-1:0]             cpu_peek,
  input  logic                     eng_we,
  input  logic [$clog2(DEPTH)-1:0] eng_widx,
  input  logic [W-1:0]             eng_wdata,
  input  logic [$clog2(DEPTH)-1:0] eng_ridx,
  output logic [W-1:0]             eng_rdata
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] cptr;

  always_ff @(posedge clk) begin
    if (cpu_we)      mem[cptr]     <= cpu_wdata;
    else if (eng_we) mem[eng_widx] <= eng_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)                    cptr <= '0;
    else if (rewind)            cptr <= '0;
    else if (cpu_we || cpu_re)  cptr <= cptr + PTR_W'(1);
  end

  assign cpu_peek  = mem[cptr];
  assign eng_rdata = mem[eng_ridx];

  // R10
  one_writer_chk: assert property (@(posedge clk) disable iff (rst)
    !(cpu_we && eng_we));
endmodule

// File: rtl/ssp_engine.sv
module ssp_engine #(
  parameter int W = 8,
  parameter int DEPTH = 8,
  parameter int HALF = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     master,
  input  logic [$clog2(DEPTH)-1:0] last_idx,
  input  logic                     start,
  input  logic                     cs_en,
  input  logic                     sck_s,
  input  logic                     si_s,
  input  logic                     si_m,
  input  logic [W-1:0]             rd_byte,
  output logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic                     wr_en,
  output logic [$clog2(DEPTH)-1:0] wr_idx,
  output logic [W-1:0]             wr_byte,
  output logic                     busy,
  output logic                     done_p,
  output logic                     abort_p,
  output logic                     sck_o,
  output logic                     so_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int BIT_W = $clog2(W);
  localparam int DIV_W = $clog2(2 * HALF);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(2 * HALF - 1);
  localparam logic [DIV_W-1:0] DIV_MID  = DIV_W'(HALF);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(W - 1);

  logic [W-1:0]     sh;
  logic [BIT_W-1:0] bits;
  logic [DIV_W-1:0] cnt;
  logic [PTR_W-1:0] idx;
  logic             sck_q, cs_q;
  logic             fall_ev, rise_ev, si_b, abort_now;

  always_comb begin
    abort_now = busy && cs_q && !cs_en;
    if (master) begin
      fall_ev = cs_en && (cnt == '0);
      rise_ev = cs_en && (cnt == DIV_MID);
      si_b    = si_m;
    end else begin
      fall_ev = sck_q && !sck_s;
      rise_ev = !sck_q && sck_s;
      si_b    = si_s;
    end
  end

  assign wr_en   = busy && !abort_now && rise_ev && (bits == BIT_LAST);
  assign wr_idx  = idx;
  assign wr_byte = {sh[W-2:0], si_b};
  assign rd_idx  = busy ? idx + PTR_W'(1) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; done_p <= 1'b0; abort_p <= 1'b0;
      sck_o <= 1'b1; so_o <= 1'b1; sh <= '0; bits <= '0;
      cnt <= '0; idx <= '0; sck_q <= 1'b1; cs_q <= 1'b0;
    end else begin
      sck_q   <= sck_s;
      cs_q    <= cs_en;
      done_p  <= 1'b0;
      abort_p <= 1'b0;
      if (!busy) begin
        sck_o <= 1'b1;
        if (start) begin
          busy <= 1'b1; sh <= rd_byte; bits <= '0; cnt <= '0; idx <= '0;
        end
      end else if (abort_now) begin
        busy <= 1'b0; abort_p <= 1'b1; bits <= '0; cnt <= '0; sck_o <= 1'b1;
      end else begin
        if (master && cs_en) cnt <= (cnt == DIV_LAST) ? '0 : cnt + DIV_W'(1);
        if (fall_ev) begin
          so_o <= sh[W-1];
          if (master) sck_o <= 1'b0;
        end
        if (rise_ev) begin
          sck_o <= 1'b1;
          bits  <= bits + BIT_W'(1);
          sh    <= {sh[W-2:0], si_b};
          if (bits == BIT_LAST) begin
            if (idx == last_idx) begin
              busy <= 1'b0; done_p <= 1'b1;
            end else begin
              idx <= idx + PTR_W'(1); sh <= rd_byte;
            end
          end
        end
      end
    end
  end

  // R9
  idle_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> bits == '0);
  // R4
  so_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(so_o) |-> $past(fall_ev && busy));
  // R5
  done_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    done_p |-> (!busy && $past(busy)));
endmodule

// File: rtl/ssp_burst.sv
module ssp_burst
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH = 8,
  parameter int SCK_HALF = 8,
  parameter int CS_GAP = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              si_i,
  output logic              so_o,
  output logic              so_oe,
  input  logic              cs_n_i,
  output logic              busy_o,
  output logic              done_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int START_BIT = DATA_W - 1;

  logic              cs_n_s, sck_s, si_s, cs_en;
  logic              master_r, done_f, err_f;
  logic [PTR_W-1:0]  len_r;
  logic              busy, done_p, abort_p;
  logic              w_ctrl, w_data, w_stat, r_data, start;
  logic [DATA_W-1:0] peek, rd_val;
  logic [PTR_W-1:0]  e_ridx, e_widx;
  logic [DATA_W-1:0] e_rbyte, e_wbyte;
  logic              e_we;

  ssp_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b110)) u_sync (
    .clk(clk), .rst(rst), .d({cs_n_i, sck_i, si_i}), .q({cs_n_s, sck_s, si_s}));

  ssp_csgate #(.GAP(CS_GAP)) u_gate (
    .clk(clk), .rst(rst), .cs_n_s(cs_n_s), .en(cs_en));

  assign w_ctrl = wr_en && (addr == REG_CTRL) && !busy;
  assign w_data = wr_en && (addr == REG_DATA) && !busy;
  assign w_stat = wr_en && (addr == REG_STAT);
  assign r_data = rd_en && (addr == REG_DATA);
  assign start  = w_ctrl && wdata[START_BIT];

  ssp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .cpu_we(w_data), .cpu_re(r_data), .rewind(w_ctrl),
    .cpu_wdata(wdata), .cpu_peek(peek), .eng_we(e_we), .eng_widx(e_widx),
    .eng_wdata(e_wbyte), .eng_ridx(e_ridx), .eng_rdata(e_rbyte));

  ssp_engine #(.W(DATA_W), .DEPTH(DEPTH), .HALF(SCK_HALF)) u_eng (
    .clk(clk), .rst(rst), .master(master_r), .last_idx(len_r), .start(start),
    .cs_en(cs_en), .sck_s(sck_s), .si_s(si_s), .si_m(si_i), .rd_byte(e_rbyte),
    .rd_idx(e_ridx), .wr_en(e_we), .wr_idx(e_widx), .wr_byte(e_wbyte),
    .busy(busy), .done_p(done_p), .abort_p(abort_p), .sck_o(sck_o), .so_o(so_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      master_r <= 1'b0; len_r <= '0; done_f <= 1'b0; err_f <= 1'b0;
    end else begin
      if (w_ctrl) begin
        master_r <= wdata[0];
        len_r    <= wdata[PTR_W:1];
      end
      done_f <= (done_f && !(w_stat && wdata[STAT_DONE])) || done_p;
      err_f  <= (err_f && !(w_stat && wdata[STAT_ERR])) || abort_p;
    end
  end

  always_comb begin
    rd_val = '0;
    case (addr)
      REG_CTRL: begin rd_val[0] = master_r; rd_val[PTR_W:1] = len_r; end
      REG_DATA: rd_val = peek;
      REG_STAT: begin
        rd_val[STAT_BUSY] = busy;
        rd_val[STAT_DONE] = done_f;
        rd_val[STAT_ERR]  = err_f;
      end
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end

  assign sck_oe = master_r && cs_en;
  assign so_oe  = cs_en;
  assign busy_o = busy;
  assign done_o = done_p;

  // R10
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(len_r) && $stable(master_r)));
  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (done_f && !(w_stat && wdata[STAT_DONE])) |=> done_f);
endmodule

// File: tb/tb_ssp_burst.sv
module tb_ssp_burst;
  localparam int CLK_PERIOD = 10;
  localparam int H  = 3;
  localparam int SH = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0, rd_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic sck_i = 1, si_i = 0, cs_n_i = 1;
  logic sck_o, sck_oe, so_o, so_oe, busy_o, done_o;

  int checks = 0, errors = 0;
  logic [7:0] txb [8];
  logic [7:0] rxb [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  ssp_burst #(.DATA_W(8), .DEPTH(8), .SCK_HALF(H), .CS_GAP(2), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .si_i(si_i),
    .so_o(so_o), .so_oe(so_oe), .cs_n_i(cs_n_i), .busy_o(busy_o), .done_o(done_o));

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
    d = rdata;
  endtask

  task automatic fill(input int n, input int seed);
    for (int k = 0; k < 8; k++) begin
      txb[k] = 8'(k * 29 + seed * 7 + 8'h3C);
      rxb[k] = 8'(~(k * 53 + seed * 11) ^ 8'h5A);
    end
    for (int k = 0; k < n; k++) wr(2'd1, txb[k]);
  endtask

  task automatic read_back(input string req, input int n, input logic [7:0] ctrl);
    logic [7:0] v;
    wr(2'd0, ctrl);
    for (int k = 0; k < n; k++) begin
      rd(2'd1, v);
      chk(req, v, rxb[k]);
    end
  endtask

  task automatic run_master(input int n, input int seed);
    logic [7:0] ctrl, v;
    int e_end;
    ctrl = 8'(((n - 1) << 1) | 1);
    wr(2'd0, ctrl);
    fill(n, seed);
    si_i = rxb[0][7];
    wr(2'd0, ctrl | 8'h80);
    e_end = (8 * n - 1) * 2 * H + H + 1;
    for (int e = 0; e <= e_end + 2; e++) begin
      int p, b, bn;
      int es, eb, ed, eso;
      eso = 0;
      if (e == 0) begin
        es = 1; eb = 1; ed = 0;
      end else if (e < e_end) begin
        p = (e - 1) % (2 * H); b = (e - 1) / (2 * H);
        es = (p < H) ? 0 : 1; eb = 1; ed = 0;
        eso = int'(txb[b / 8][7 - b % 8]);
      end else begin
        es = 1; eb = 0; ed = (e == e_end) ? 1 : 0;
        eso = int'(txb[n - 1][0]);
      end
      chk("R3 sck_o", sck_o, es);
      chk("R5 busy_o", busy_o, eb);
      chk("R6 done_o", done_o, ed);
      chk("R7 sck_oe", sck_oe, 1);
      if (e > 0) chk("R4 so_o", so_o, eso);
      bn = e / (2 * H);
      if (bn < 8 * n) si_i = rxb[bn / 8][7 - bn % 8];
      @(negedge clk);
    end
    rd(2'd2, v);
    chk("R6 done flag", v, 8'h02);
    read_back("R5 received bytes", n, ctrl);
    wr(2'd2, 8'h02);
    rd(2'd2, v);
    chk("R6 write-1 clear", v, 8'h00);
  endtask

  task automatic slave_bits(input int n, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      sck_i = 0;
      si_i = rxb[i / 8][7 - i % 8];
      repeat (SH) @(negedge clk);
      chk("R8 slave so_o", so_o, txb[i / 8][7 - i % 8]);
      chk("R7 so_oe", so_oe, 1);
      chk("R7 sck_oe slave", sck_oe, 0);
      sck_i = 1;
      repeat (SH) @(negedge clk);
    end
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy_o", busy_o, 0);
    chk("R1 sck_o", sck_o, 1);
    chk("R1 sck_oe", sck_oe, 0);
    chk("R1 so_oe", so_oe, 0);
    chk("R1 done_o", done_o, 0);
    rd(2'd2, v); chk("R1 STAT", v, 0);
    rd(2'd0, v); chk("R1 CTRL", v, 0);

    cs_n_i = 0;
    repeat (5) @(negedge clk);
    chk("R7 so_oe open", so_oe, 1);

    // R2 queue load and unload order
    wr(2'd0, 8'h00);
    wr(2'd1, 8'hC1); wr(2'd1, 8'hC2); wr(2'd1, 8'hC3);
    wr(2'd0, 8'h00);
    rd(2'd1, v); chk("R2 entry0", v, 8'hC1);
    rd(2'd1, v); chk("R2 entry1", v, 8'hC2);
    rd(2'd1, v); chk("R2 entry2", v, 8'hC3);

    // R11 CTRL readback
    wr(2'd0, 8'h0B);
    rd(2'd0, v); chk("R11 CTRL readback", v, 8'h0B);

    // master bursts: single byte, full queue, mid length
    run_master(1, 1);
    run_master(8, 2);
    run_master(3, 3);

    // R10 writes during a burst are ignored
    wr(2'd0, 8'h03);
    wr(2'd1, 8'h11); wr(2'd1, 8'h22); wr(2'd1, 8'h33); wr(2'd1, 8'h44);
    si_i = 1;
    wr(2'd0, 8'h83);
    rd(2'd2, v); chk("R11 STAT busy bit", v, 8'h01);
    wr(2'd0, 8'h0F);
    wr(2'd1, 8'h55);
    while (busy_o) @(negedge clk);
    rd(2'd0, v); chk("R10 CTRL kept", v, 8'h03);
    wr(2'd0, 8'h03);
    rd(2'd1, v); chk("R10 entry0", v, 8'hFF);
    rd(2'd1, v); chk("R10 entry1", v, 8'hFF);
    rd(2'd1, v); chk("R10 entry2", v, 8'h33);
    rd(2'd1, v); chk("R10 entry3", v, 8'h44);
    wr(2'd2, 8'h06);

    // R8 slave burst of two bytes
    wr(2'd0, 8'h02);
    fill(2, 4);
    wr(2'd0, 8'h82);
    chk("R5 slave busy", busy_o, 1);
    slave_bits(2, 16);
    chk("R8 slave done", busy_o, 0);
    rd(2'd2, v); chk("R6 slave done flag", v, 8'h02);
    read_back("R8 slave received", 2, 8'h02);
    wr(2'd2, 8'h02);

    // R9 abort by chip select mid burst
    wr(2'd0, 8'h02);
    fill(2, 5);
    wr(2'd0, 8'h82);
    slave_bits(2, 5);
    cs_n_i = 1;
    repeat (6) @(negedge clk);
    chk("R9 busy cleared", busy_o, 0);
    chk("R7 so_oe floated", so_oe, 0);
    rd(2'd2, v); chk("R9 error flag", v, 8'h04);
    wr(2'd2, 8'h04);
    rd(2'd2, v); chk("R9 error cleared", v, 8'h00);
    cs_n_i = 0;
    repeat (6) @(negedge clk);
    wr(2'd0, 8'h00);
    fill(1, 6);
    wr(2'd0, 8'h80);
    slave_bits(1, 8);
    chk("R9 restart done", busy_o, 0);
    read_back("R9 restart from bit 0", 1, 8'h00);
    wr(2'd2, 8'h02);

    // R7 a one-clock deselect is too short to reopen the gate
    cs_n_i = 1;
    @(negedge clk);
    cs_n_i = 0;
    repeat (5) @(negedge clk);
    chk("R7 short gap stays closed", so_oe, 0);
    cs_n_i = 1;
    repeat (3) @(negedge clk);
    cs_n_i = 0;
    repeat (5) @(negedge clk);
    chk("R7 full gap reopens", so_oe, 1);
    wr(2'd0, 8'h01);
    chk("R7 sck_oe master", sck_oe, 1);

    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1..R11 actual=running expected=finished");
    report();
    $finish;
  end
endmodule